// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Acknowledge Unit

This block joins two eight-input interrupt resolvers into a two-level cascade. The primary resolver serves request lines 0 to 7. The secondary resolver serves lines 8 to 15, and its winning request is fed into primary input 2. The processor sees one interrupt line. When the processor acknowledges an interrupt, the unit does four things: it picks the winning source, marks it in service in the right resolver or resolvers, forms the 8-bit vector from the matching vector base, and reports the 4-bit line number. Spurious acknowledges on either level resolve to index 7.

Each resolver latches rising edges on its inputs as pending requests. It uses fixed priority, where the lowest index is the most urgent. It raises a winner only when the pending request outranks everything already in service. A nonspecific end-of-interrupt strobe for each level clears the most urgent in-service bit. A nesting-mode input makes the primary resolver leave out its own in-service bit 2 when it ranks requests, so a more urgent secondary request can nest inside a secondary service routine.

Vector base values, end-of-interrupt strobes and the nesting mode come in as plain inputs. No register programming exists inside the block.

Top module: `cascade_ack_unit`

## Requirements
- R1: Request line k goes to the primary resolver when k < 8, or to the secondary resolver with local index k-8. Inside each resolver, the lowest pending index wins.
- R2: A request latches only on a 0-to-1 transition of its line. A line held high after its request was acknowledged does not request again.
- R3: When the secondary resolver has a winner, primary input 2 becomes pending one clock later. `irq_o` is high exactly while the primary resolver has a winner.
- R4: Acknowledging a primary winner other than 2 gives line = index and vector = {primary base[7:3], index}.
- R5: Acknowledging primary input 2 while the secondary resolver has a winner also acknowledges the secondary resolver. It gives line = 8 + index and vector = {secondary base[7:3], index}.
- R6: Acknowledging primary input 2 while the secondary resolver has no winner gives line 15 and vector = {secondary base[7:3], 3'b111}.
- R7: An acknowledge with no primary winner gives line 7 and vector = {primary base[7:3], 3'b111}. It changes no pending or in-service state.
- R8: A pending request wins only if its index is lower than the lowest in-service index. An end-of-interrupt strobe clears the lowest set in-service bit of its level.
- R9: With `nest_mode_i` high, the primary resolver leaves its in-service bit 2 out of that comparison.
- R10: The low three bits of both vector bases never reach the vector.
- R11: `vec_o` and `line_o` update on the clock edge that samples `ack_i` and hold between acknowledges. `vec_valid_o` is high for exactly the cycle after each sampled acknowledge.
- R12: After reset, `irq_o`, `vec_valid_o`, `vec_o` and `line_o` are all zero, and nothing is pending or in service.
- R13: In the acknowledge cycle the secondary resolver does not feed primary input 2. Once a queued secondary request wins again, for example after end-of-interrupt on both levels, the primary resolver is raised again one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Request lines, 0-7 primary, 8-15 secondary |
| nest_mode_i | input | 1 | Primary ignores its in-service bit 2 when ranking |
| eoi_pri_i | input | 1 | Nonspecific end-of-interrupt, primary level |
| eoi_sec_i | input | 1 | Nonspecific end-of-interrupt, secondary level |
| vbase_pri_i | input | 8 | Primary vector base (bits 7:3 used) |
| vbase_sec_i | input | 8 | Secondary vector base (bits 7:3 used) |
| ack_i | input | 1 | Processor acknowledge strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Registered vector of the last acknowledge |
| line_o | output | 4 | Registered line number of the last acknowledge |
| vec_valid_o | output | 1 | One-cycle pulse after each acknowledge |

## Verification
The bench targets the two spurious paths, because a design that mixes them up returns the wrong base. It would report line 7 from the primary base where line 15 from the secondary base is required, or the reverse.

It also targets in-service blocking and the nesting mode. A resolver that compares with <= instead of <, or never leaves out bit 2, either lets a less urgent request through or keeps a more urgent secondary request from nesting.

The re-raise case checks that a queued secondary request raises the interrupt again one clock after both end-of-interrupt strobes, and not before. The held-line case catches a resolver that treats levels as requests, which would raise a fresh interrupt after end-of-interrupt.

// File: rtl/cascade_pkg.sv
package cascade_pkg;

    localparam int CTRL_LINES = 8;
    localparam int CASC_INPUT = 2;
    localparam int VEC_BITS   = 8;

endpackage

// File: rtl/irq_resolver.sv
module irq_resolver #(
    parameter int N    = 8,
    parameter int CASC = 2,
    parameter int IW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  line_i,
    input  logic [N-1:0]  force_i,
    input  logic          ack_i,
    input  logic [IW-1:0] ack_idx_i,
    input  logic          eoi_i,
    input  logic          skip_casc_i,
    output logic          win_valid_o,
    output logic [IW-1:0] win_idx_o
);

    typedef struct packed {
        logic [N-1:0] last;
        logic [N-1:0] irr;
        logic [N-1:0] isr;
    } res_state_t;

    res_state_t state_d, state_q;

    function automatic logic [IW:0] first_set(input logic [N-1:0] v);
        logic          found;
        logic [IW-1:0] idx;
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        return {found, idx};
    endfunction

    logic [N-1:0]  rise, isr_rank_src, ack_vec, eoi_vec;
    logic          irr_any, rank_any, isr_any;
    logic [IW-1:0] irr_idx, rank_idx, isr_top;

    always_comb begin
        rise         = line_i & ~state_q.last;
        isr_rank_src = state_q.isr;
        if (skip_casc_i) begin
            isr_rank_src[CASC] = 1'b0;
        end
        {irr_any, irr_idx}   = first_set(state_q.irr);
        {rank_any, rank_idx} = first_set(isr_rank_src);
        {isr_any, isr_top}   = first_set(state_q.isr);

        win_valid_o = irr_any && (!rank_any || (irr_idx < rank_idx));
        win_idx_o   = irr_idx;

        ack_vec = ack_i ? (N'(1) << ack_idx_i) : '0;
        eoi_vec = (eoi_i && isr_any) ? (N'(1) << isr_top) : '0;

        state_d.last = line_i;
        state_d.irr  = (state_q.irr & ~ack_vec) | rise | force_i;
        state_d.isr  = (state_q.isr & ~eoi_vec) | ack_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/ack_decode.sv
module ack_decode #(
    parameter int IW   = 3,
    parameter int VW   = 8,
    parameter int CASC = 2
) (
    input  logic          ack_i,
    input  logic          pri_valid_i,
    input  logic [IW-1:0] pri_idx_i,
    input  logic          sec_valid_i,
    input  logic [IW-1:0] sec_idx_i,
    input  logic [VW-1:0] pri_base_i,
    input  logic [VW-1:0] sec_base_i,
    output logic          pri_ack_o,
    output logic          sec_ack_o,
    output logic [VW-1:0] vec_o,
    output logic [IW:0]   line_o
);

    localparam logic [IW-1:0] SPUR_IDX = '1;

    always_comb begin
        pri_ack_o = 1'b0;
        sec_ack_o = 1'b0;
        vec_o     = {pri_base_i[VW-1:IW], SPUR_IDX};
        line_o    = {1'b0, SPUR_IDX};
        if (pri_valid_i) begin
            pri_ack_o = ack_i;
            if (pri_idx_i == IW'(CASC)) begin
                sec_ack_o = ack_i && sec_valid_i;
                if (sec_valid_i) begin
                    vec_o  = {sec_base_i[VW-1:IW], sec_idx_i};
                    line_o = {1'b1, sec_idx_i};
                end else begin
                    vec_o  = {sec_base_i[VW-1:IW], SPUR_IDX};
                    line_o = {1'b1, SPUR_IDX};
                end
            end else begin
                vec_o  = {pri_base_i[VW-1:IW], pri_idx_i};
                line_o = {1'b0, pri_idx_i};
            end
        end
    end

endmodule

// File: rtl/cascade_ack_unit.sv
module cascade_ack_unit
    import cascade_pkg::*;
#(
    parameter int LINES = CTRL_LINES,
    parameter int VW    = VEC_BITS,
    parameter int IW    = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*LINES-1:0] req_i,
    input  logic               nest_mode_i,
    input  logic               eoi_pri_i,
    input  logic               eoi_sec_i,
    input  logic [VW-1:0]      vbase_pri_i,
    input  logic [VW-1:0]      vbase_sec_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [VW-1:0]      vec_o,
    output logic [IW:0]        line_o,
    output logic               vec_valid_o
);

    typedef struct packed {
        logic [VW-1:0] vec;
        logic [IW:0]   line;
        logic          valid;
    } out_t;

    out_t out_d, out_q;

    logic             pri_win, sec_win, pri_ack, sec_ack;
    logic [IW-1:0]    pri_idx, sec_idx;
    logic [LINES-1:0] pri_force;
    logic [VW-1:0]    dec_vec;
    logic [IW:0]      dec_line;

    always_comb begin
        pri_force            = '0;
        pri_force[CASC_INPUT] = sec_win && !ack_i;
    end

    irq_resolver #(.N(LINES), .CASC(CASC_INPUT), .IW(IW)) u_pri (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (req_i[LINES-1:0]),
        .force_i     (pri_force),
        .ack_i       (pri_ack),
        .ack_idx_i   (pri_idx),
        .eoi_i       (eoi_pri_i),
        .skip_casc_i (nest_mode_i),
        .win_valid_o (pri_win),
        .win_idx_o   (pri_idx)
    );

    irq_resolver #(.N(LINES), .CASC(CASC_INPUT), .IW(IW)) u_sec (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (req_i[2*LINES-1:LINES]),
        .force_i     ('0),
        .ack_i       (sec_ack),
        .ack_idx_i   (sec_idx),
        .eoi_i       (eoi_sec_i),
        .skip_casc_i (1'b0),
        .win_valid_o (sec_win),
        .win_idx_o   (sec_idx)
    );

    ack_decode #(.IW(IW), .VW(VW), .CASC(CASC_INPUT)) u_dec (
        .ack_i       (ack_i),
        .pri_valid_i (pri_win),
        .pri_idx_i   (pri_idx),
        .sec_valid_i (sec_win),
        .sec_idx_i   (sec_idx),
        .pri_base_i  (vbase_pri_i),
        .sec_base_i  (vbase_sec_i),
        .pri_ack_o   (pri_ack),
        .sec_ack_o   (sec_ack),
        .vec_o       (dec_vec),
        .line_o      (dec_line)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        if (ack_i) begin
            out_d.vec   = dec_vec;
            out_d.line  = dec_line;
            out_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_o       = pri_win;
    assign vec_o       = out_q.vec;
    assign line_o      = out_q.line;
    assign vec_valid_o = out_q.valid;

endmodule

// File: rtl/cascade_ack_checker.sv
module cascade_ack_checker #(
    parameter int VW = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_i,
    input logic          irq_o,
    input logic [VW-1:0] vbase_pri_i,
    input logic [VW-1:0] vbase_sec_i,
    input logic [VW-1:0] vec_o,
    input logic [IW:0]   line_o,
    input logic          vec_valid_o
);

    // R11: one valid pulse per sampled acknowledge
    p_valid_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> vec_valid_o);
    p_no_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> !vec_valid_o);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |=> ($stable(vec_o) && $stable(line_o)));

    // R4, R5, R6, R7: low vector bits equal the local index
    p_vec_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (vec_o[IW-1:0] == line_o[IW-1:0]));

    // R10: upper vector bits come from the base of the level
    p_vec_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (line_o[IW] ? (vec_o[VW-1:IW] == $past(vbase_sec_i[VW-1:IW]))
                              : (vec_o[VW-1:IW] == $past(vbase_pri_i[VW-1:IW]))));

    // R7: acknowledge with no request reports primary spurious line
    p_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o) |=> (line_o == {1'b0, {IW{1'b1}}}));

endmodule

bind cascade_ack_unit cascade_ack_checker #(.VW(VW), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .irq_o       (irq_o),
    .vbase_pri_i (vbase_pri_i),
    .vbase_sec_i (vbase_sec_i),
    .vec_o       (vec_o),
    .line_o      (line_o),
    .vec_valid_o (vec_valid_o)
);

// File: tb/cascade_ack_unit_bench.sv
module cascade_ack_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic        nest = 1'b0, eoi_p = 1'b0, eoi_s = 1'b0, ack = 1'b0;
    logic [7:0]  base_p = 8'h23, base_s = 8'h7F;
    logic        irq, valid;
    logic [7:0]  vec;
    logic [3:0]  line;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cascade_ack_unit u_cascade_ack_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .nest_mode_i (nest),
        .eoi_pri_i   (eoi_p),
        .eoi_sec_i   (eoi_s),
        .vbase_pri_i (base_p),
        .vbase_sec_i (base_s),
        .ack_i       (ack),
        .irq_o       (irq),
        .vec_o       (vec),
        .line_o      (line),
        .vec_valid_o (valid)
    );

    // table: request pattern, expected irq, line, vector (bases 0x23 -> 0x20, 0x7F -> 0x78)
    localparam int NT = 10;
    localparam logic [15:0] T_REQ [NT] = '{16'h0001, 16'h0008, 16'h00A0, 16'h0100, 16'h8000,
                                           16'h0110, 16'h0003, 16'h0C00, 16'h0000, 16'h0090};
    localparam logic        T_IRQ [NT] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [3:0]  T_LINE [NT] = '{4'd0, 4'd3, 4'd5, 4'd8, 4'd15, 4'd8, 4'd0, 4'd10, 4'd7, 4'd4};
    localparam logic [7:0]  T_VEC [NT] = '{8'h20, 8'h23, 8'h25, 8'h78, 8'h7F,
                                           8'h78, 8'h20, 8'h7A, 8'h27, 8'h24};

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; ack = 1'b0; eoi_p = 1'b0; eoi_s = 1'b0; nest = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R12: reset state
        do_reset();
        chk("R12 irq", 16'(irq), 16'h0);
        chk("R12 valid", 16'(valid), 16'h0);
        chk("R12 vec", 16'(vec), 16'h0);
        chk("R12 line", 16'(line), 16'h0);

        // R7 / R11: acknowledge with nothing pending, then pulse ends and value holds
        do_ack();
        chk("R7 line", 16'(line), 16'h7);
        chk("R7 vec", 16'(vec), 16'h27);
        chk("R11 valid pulse", 16'(valid), 16'h1);
        chk("R7 irq stays low", 16'(irq), 16'h0);
        tick();
        chk("R11 valid drops", 16'(valid), 16'h0);
        chk("R11 vec held", 16'(vec), 16'h27);

        // R1, R3, R4, R5, R10: table walk
        for (int k = 0; k < NT; k++) begin
            do_reset();
            req = T_REQ[k];
            tick(); tick();
            chk($sformatf("R3 irq entry %0d", k), 16'(irq), 16'(T_IRQ[k]));
            do_ack();
            chk($sformatf("R1 R4 R5 line entry %0d", k), 16'(line), 16'(T_LINE[k]));
            chk($sformatf("R10 vec entry %0d", k), 16'(vec), 16'(T_VEC[k]));
            chk($sformatf("R11 valid entry %0d", k), 16'(valid), 16'h1);
        end

        // R6: primary input 2 raised directly, secondary has nothing
        do_reset();
        req = 16'h0004;
        tick();
        chk("R6 irq", 16'(irq), 16'h1);
        do_ack();
        chk("R6 line", 16'(line), 16'hF);
        chk("R6 vec", 16'(vec), 16'h7F);

        // R8 and R2: in-service blocking, EOI order, held line does not re-request
        do_reset();
        req = 16'h0008;
        tick();
        do_ack();
        chk("R8 first line", 16'(line), 16'h3);
        req = 16'h0028;
        tick(); tick();
        chk("R8 less urgent blocked", 16'(irq), 16'h0);
        req = 16'h002A;
        tick();
        chk("R8 more urgent passes", 16'(irq), 16'h1);
        do_ack();
        chk("R8 nested line", 16'(line), 16'h1);
        eoi_p = 1'b1; tick(); eoi_p = 1'b0;
        chk("R8 still blocked by 3", 16'(irq), 16'h0);
        eoi_p = 1'b1; tick(); eoi_p = 1'b0;
        chk("R8 released after second EOI", 16'(irq), 16'h1);
        do_ack();
        chk("R8 line 5", 16'(line), 16'h5);
        eoi_p = 1'b1; tick(); eoi_p = 1'b0;
        tick();
        chk("R2 held lines no new request", 16'(irq), 16'h0);

        // R9: nesting mode lets a more urgent secondary request through
        do_reset();
        req = 16'h1000;
        tick(); tick();
        do_ack();
        chk("R9 first line", 16'(line), 16'hC);
        chk("R9 first vec", 16'(vec), 16'h7C);
        req = 16'h1200;
        tick(); tick(); tick();
        chk("R9 blocked without mode", 16'(irq), 16'h0);
        nest = 1'b1;
        tick();
        chk("R9 raised with mode", 16'(irq), 16'h1);
        do_ack();
        chk("R9 nested line", 16'(line), 16'h9);
        chk("R9 nested vec", 16'(vec), 16'h79);
        nest = 1'b0;

        // R13: queued secondary request re-raises one clock after EOI on both levels
        do_reset();
        req = 16'h3000;
        tick(); tick();
        do_ack();
        chk("R13 first line", 16'(line), 16'hC);
        tick();
        chk("R13 no raise while in service", 16'(irq), 16'h0);
        eoi_p = 1'b1; eoi_s = 1'b1;
        tick();
        eoi_p = 1'b0; eoi_s = 1'b0;
        chk("R13 not yet raised", 16'(irq), 16'h0);
        tick();
        chk("R13 raised", 16'(irq), 16'h1);
        do_ack();
        chk("R13 queued line", 16'(line), 16'hD);
        chk("R13 queued vec", 16'(vec), 16'h7D);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule